// File: doc/BRIEF.md
# Staggered Bit-Slice Write Controller

This block drives the write side of a serial-to-parallel converter built from a bank of bit-sliced dual-port memories. Eight lanes of serial data arrive with a skew of one bit period between adjacent lanes. The controller gives each lane's multiplexer and memory group a 3-bit address. The eight addresses count together, but each lane starts one step behind its neighbour, so in any cycle the lanes point at eight different channels.

Alongside the lane addresses, a 32-bit enable pattern selects which memories are written. The pattern is a rotating shift register that holds a circular window of eight set bits. A 4-bit half-select group picks which half of the double-buffered memory is being filled. It flips each time a 32-bit buffer completes, and a one-cycle strobe reports each filled buffer. All state advances only in cycles where the write enable is high. A synchronous reset returns everything to its start values.

Top module: `bitslice_wr_ctrl`

## Requirements
- R1: After reset, lane k's address (bits [3k+2:3k] of `lane_addr`) is (8-k) mod 8, so lane 0 is 0 and lanes 1..7 are 7,6,...,1. `mem_we` is 32'hFE000001, `half_sel` is 4'h0 and `buf_done` is 0.
- R2: In each cycle with `wr_en` high, all eight lane addresses increase by one modulo 8 on the same clock edge.
- R3: At all times, lane k's address equals lane 0's address minus k, modulo 8.
- R4: In each cycle with `wr_en` high, `mem_we` rotates left by one position, and bit 31 moves into bit 0.
- R5: `mem_we` always has exactly eight set bits, and they form one contiguous window modulo 32.
- R6: In a cycle with `wr_en` low, the lane addresses, `mem_we` and `half_sel` keep their values.
- R7: All four bits of `half_sel` invert together on the edge that completes the 32nd enabled cycle of a buffer. They change at no other time.
- R8: `buf_done` is high for exactly the one cycle that follows the edge completing the 32nd enabled cycle of a buffer, whether `wr_en` is high or low in that cycle.
- R9: At every buffer boundary, the lane addresses and `mem_we` are back at their reset values.
- R10: `rst` is synchronous and active high. It overrides `wr_en`, including on an edge that would otherwise complete a buffer, and in that case no `buf_done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Advance enable, one bit period per high cycle |
| mem_we | output | 32 | Rotating memory write-enable pattern |
| half_sel | output | 4 | Double-buffer half select, all bits equal |
| lane_addr | output | 24 | Eight packed 3-bit lane addresses, lane k at [3k+2:3k] |
| buf_done | output | 1 | One-cycle pulse per completed 32-bit buffer |

## Verification
Two events can land on the same edge. A buffer can complete on the edge where reset is asserted, and the cycle right after a completion can be a stall with `wr_en` low. The bench steers a behavioural model to the 31st beat of a buffer and then applies each collision. On the reset collision it expects the reset values and no strobe. On the stall collision it expects exactly one strobe while the addresses, the pattern and the flipped half-select all hold. Each comparison is made on every clock.

// File: rtl/s2p_wrctl_pkg.sv
package s2p_wrctl_pkg;

    localparam int DEF_LANES  = 8;
    localparam int DEF_SLICES = 32;
    localparam int DEF_HALF_W = 4;

    // Start offset of a lane: lane 0 at zero, each further lane one step behind.
    function automatic int lane_start(input int lane, input int lanes);
        return (lanes - lane) % lanes;
    endfunction

endpackage

// File: rtl/wrctl_lane_ctr.sv
module wrctl_lane_ctr #(
    parameter int ADDR_W = 3,
    parameter int START  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] START_V = ADDR_W'(START);

    typedef struct packed {
        logic [ADDR_W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (rst) begin
            ctr_d.cnt = START_V;
        end else if (adv) begin
            ctr_d.cnt = ctr_q.cnt + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        ctr_q <= ctr_d;
    end

    assign addr = ctr_q.cnt;

    assert_lane_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(addr));

endmodule

// File: rtl/wrctl_rotor.sv
module wrctl_rotor #(
    parameter int SLICES = 32,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [SLICES-1:0] pattern
);

    function automatic logic [SLICES-1:0] window_init();
        logic [SLICES-1:0] v;
        v = '0;
        for (int i = 0; i < LANES; i++) begin
            v[(SLICES - LANES + 1 + i) % SLICES] = 1'b1;
        end
        return v;
    endfunction

    localparam logic [SLICES-1:0] INIT = window_init();

    typedef struct packed {
        logic [SLICES-1:0] pat;
    } rot_t;

    rot_t rot_d, rot_q;

    always_comb begin
        rot_d = rot_q;
        if (rst) begin
            rot_d.pat = INIT;
        end else if (adv) begin
            rot_d.pat = {rot_q.pat[SLICES-2:0], rot_q.pat[SLICES-1]};
        end
    end

    always_ff @(posedge clk) begin
        rot_q <= rot_d;
    end

    assign pattern = rot_q.pat;

    assert_window_size_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(pattern) == LANES);

    assert_window_contig_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(pattern & {pattern[SLICES-2:0], pattern[SLICES-1]}) == LANES - 1);

    assert_pattern_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(pattern));

endmodule

// File: rtl/wrctl_buf_track.sv
module wrctl_buf_track #(
    parameter int SLICES = 32,
    parameter int HALF_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [HALF_W-1:0] half_sel,
    output logic              done
);

    localparam int                BEAT_W = $clog2(SLICES);
    localparam logic [BEAT_W-1:0] LAST   = BEAT_W'(SLICES - 1);

    typedef struct packed {
        logic [BEAT_W-1:0] beat;
        logic [HALF_W-1:0] half;
        logic              done;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        trk_d.done = 1'b0;
        if (rst) begin
            trk_d.beat = '0;
            trk_d.half = '0;
        end else if (adv) begin
            if (trk_q.beat == LAST) begin
                trk_d.beat = '0;
                trk_d.half = ~trk_q.half;
                trk_d.done = 1'b1;
            end else begin
                trk_d.beat = trk_q.beat + BEAT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        trk_q <= trk_d;
    end

    assign half_sel = trk_q.half;
    assign done     = trk_q.done;

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_half_moves_on_done_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(half_sel) |-> done);

    assert_half_uniform_R7: assert property (@(posedge clk) disable iff (rst)
        (half_sel == '0) || (half_sel == '1));

endmodule

// File: rtl/bitslice_wr_ctrl.sv
module bitslice_wr_ctrl #(
    parameter int LANES  = s2p_wrctl_pkg::DEF_LANES,
    parameter int SLICES = s2p_wrctl_pkg::DEF_SLICES,
    parameter int HALF_W = s2p_wrctl_pkg::DEF_HALF_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    output logic [SLICES-1:0]         mem_we,
    output logic [HALF_W-1:0]         half_sel,
    output logic [LANES*$clog2(LANES)-1:0] lane_addr,
    output logic                      buf_done
);

    localparam int ADDR_W = $clog2(LANES);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        wrctl_lane_ctr #(
            .ADDR_W (ADDR_W),
            .START  (s2p_wrctl_pkg::lane_start(k, LANES))
        ) u_ctr (
            .clk  (clk),
            .rst  (rst),
            .adv  (wr_en),
            .addr (lane_addr[k*ADDR_W +: ADDR_W])
        );
    end

    wrctl_rotor #(
        .SLICES (SLICES),
        .LANES  (LANES)
    ) u_rotor (
        .clk     (clk),
        .rst     (rst),
        .adv     (wr_en),
        .pattern (mem_we)
    );

    wrctl_buf_track #(
        .SLICES (SLICES),
        .HALF_W (HALF_W)
    ) u_track (
        .clk      (clk),
        .rst      (rst),
        .adv      (wr_en),
        .half_sel (half_sel),
        .done     (buf_done)
    );

    // Lanes driven by separate counters must keep their fixed skew.
    for (genvar k = 1; k < LANES; k++) begin : g_skew_chk
        assert_lane_skew_R3: assert property (@(posedge clk) disable iff (rst)
            lane_addr[k*ADDR_W +: ADDR_W] ==
            ADDR_W'(lane_addr[0 +: ADDR_W] - ADDR_W'(k)));
    end

    // At a buffer boundary the pattern window must sit back at its start place.
    assert_boundary_pattern_R9: assert property (@(posedge clk) disable iff (rst)
        buf_done |-> (mem_we[0] && mem_we[SLICES-1] && !mem_we[1]));

    assert_boundary_lane_R9: assert property (@(posedge clk) disable iff (rst)
        buf_done |-> (lane_addr[0 +: ADDR_W] == '0));

endmodule

// File: tb/bitslice_wr_ctrl_tb.sv
module bitslice_wr_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] mem_we;
    logic [3:0]  half_sel;
    logic [23:0] lane_addr;
    logic        buf_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string phase = "R1";

    // Behavioural reference state
    int total_m = 0;
    int beats_m = 0;
    bit half_m  = 1'b0;
    bit done_m  = 1'b0;

    always #10 clk = ~clk;

    bitslice_wr_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .mem_we    (mem_we),
        .half_sel  (half_sel),
        .lane_addr (lane_addr),
        .buf_done  (buf_done)
    );

    function automatic logic [31:0] exp_pattern(input int n);
        logic [31:0] p;
        p = 32'hFE000001;
        for (int i = 0; i < n % 32; i++) p = {p[30:0], p[31]};
        return p;
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int k = 0; k < 8; k++) begin
            check($sformatf("R2 R3 lane%0d", k), 32'(lane_addr[k*3 +: 3]),
                  32'(((total_m % 8) + 8 - k) % 8));
        end
        check("R4 R5 mem_we", mem_we, exp_pattern(total_m));
        check("R7 half_sel", 32'(half_sel), half_m ? 32'hF : 32'h0);
        check("R8 buf_done", 32'(buf_done), 32'(done_m));
    endtask

    task automatic step(input bit en, input bit r);
        wr_en = en;
        rst   = r;
        @(posedge clk);
        if (r) begin
            total_m = 0; beats_m = 0; half_m = 1'b0; done_m = 1'b0;
        end else begin
            done_m = 1'b0;
            if (en) begin
                total_m++;
                beats_m++;
                if (beats_m == 32) begin
                    beats_m = 0;
                    half_m  = ~half_m;
                    done_m  = 1'b1;
                end
            end
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic run_to_last_beat();
        while (beats_m != 31) step(1'b1, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        phase = "R1";
        repeat (3) step(1'b1, 1'b1);

        phase = "R2 R7 R8 R9";
        repeat (70) step(1'b1, 1'b0);

        phase = "R6";
        for (int i = 0; i < 30; i++) step(i % 2 == 0, 1'b0);

        phase = "R6 R8 stall after boundary";
        run_to_last_beat();
        step(1'b1, 1'b0);
        repeat (4) step(1'b0, 1'b0);
        step(1'b1, 1'b0);

        phase = "R4 R5 random";
        repeat (300) step(($urandom % 4) != 0, 1'b0);

        phase = "R10 reset on boundary";
        run_to_last_beat();
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);

        phase = "R10 mid-run reset";
        repeat (13) step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        repeat (5) step(1'b0, 1'b0);

        phase = "R2 R9 random";
        repeat (200) step(($urandom % 3) != 0, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule